// File: doc/BRIEF.md
# MSI and INTx Interrupt Hub

This block gathers the interrupt sources of one PCIe root port into a single level-sensitive interrupt line for the host. Four legacy wire interrupts (INTA to INTD) and up to 32 message-signalled vectors are latched into sticky status bits. Software clears each bit by writing a 1 to it, and a mask register selects which sources may raise the line.

Message-signalled interrupts arrive as inbound memory writes on a sideband. Each such write carries a 64-bit address and a 32-bit payload. When the address equals the programmed target (a 32-bit address, so the upper half must be zero), the low five payload bits select the vector bit to set. Any pending vector also raises a single MSI summary bit in the status register, next to the four INTx bits. This lets one status read tell software which class of source needs service.

Register access uses a simple request bus. A write takes effect at the clock edge where it is presented. A read returns the value held before that edge, one cycle later, together with a valid flag.

Top module: `msi_intx_irq_hub`

## Requirements
- R1: The status register (offset 0x00) holds one sticky bit per wire interrupt at bits 16 (INTA), 17 (INTB), 18 (INTC) and 19 (INTD). A bit is set at every edge where its `intxIn` line is high. Writing 1 to the bit clears it, and writing 0 leaves it unchanged.
- R2: Status bit 23 is the MSI summary. It sets at the same edge as any vector bit set by an inbound hit, and writing 1 clears it. If vector bits are still pending after such a clear, the summary reads 0 for exactly one cycle and is set again at the next edge.
- R3: The mask register (offset 0x04) uses bits 19:16 for INTD..INTA and bit 23 for the MSI summary. A 1 masks the source and a 0 enables it. It resets to 0x008F0000, and all its other bits read 0.
- R4: The vector register (offset 0x08) holds 32 sticky bits, one per message vector. Writing 1 to a bit clears that vector.
- R5: The target register (offset 0x0C) is a 32-bit read/write register that resets to 0. An inbound write whose address bits 31:0 equal the target and whose bits 63:32 are zero sets the vector bit indexed by payload bits 4:0.
- R6: An inbound write with any of address bits 63:32 set, or with bits 31:0 different from the target, changes no vector bit.
- R7: When a set event and a write-one-to-clear hit the same status or vector bit at the same edge, the bit ends up set.
- R8: `irqOut` is registered. It is high in the cycle after any status bit (INTx bits and the MSI summary) is set while its mask bit is 0, and low otherwise.
- R9: A read request returns the register value from before that edge, on `regRdata`, with `regRdValid` high for exactly the following cycle. Unused bits and unmapped offsets read 0.
- R10: After reset all status and vector bits are 0 and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid with regRdValid |
| regRdValid | output | 1 | Read data valid, one cycle after the request |
| intxIn | input | 4 | Wire interrupt levels, bit 0 = INTA |
| inbValid | input | 1 | Inbound memory write present |
| inbAddr | input | 64 | Inbound write address |
| inbData | input | 32 | Inbound write payload |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
The hardest situation to reach is the one-cycle gap in the MSI summary, when software clears it while vectors are still pending. Seeing that gap at the ports needs a read issued in the very cycle after the clear write. The stimulus therefore drives a write and a read back to back, with no idle cycle between them, and expects 0 followed by a re-set summary. A second case to force is a clear and a set landing on the same bit at the same edge. The bench reaches it by driving a vector-clear write and an inbound hit to that same vector in one cycle, and by holding a wire interrupt high while its status bit is cleared. A behavioural model tracks every edge, so the interrupt line and all read data are compared in each cycle.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;
  localparam int REG_W       = 32;
  localparam int OFS_STATUS  = 'h00;
  localparam int OFS_MASK    = 'h04;
  localparam int OFS_VECTOR  = 'h08;
  localparam int OFS_TARGET  = 'h0C;
  localparam int INTX_LSB    = 16;
  localparam int NUM_INTX    = 4;
  localparam int MSI_SUM_BIT = 23;

  // Strobes from control to datapath, one per register write.
  typedef struct packed {
    logic             clrStatus;
    logic             wrMask;
    logic             clrVector;
    logic             wrTarget;
    logic [REG_W-1:0] data;
  } regStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_MASK, SEL_VECTOR, SEL_TARGET
  } rdSel_e;
endpackage

// File: rtl/irqhub_stickybit.sv
module irqhub_stickybit (
  input  logic clk,
  input  logic rstN,
  input  logic setIn,
  input  logic clrIn,
  output logic q
);
  // A set at the same edge as a clear wins.
  always_ff @(posedge clk) begin
    if (!rstN) q <= 1'b0;
    else       q <= setIn | (q & ~clrIn);
  end
endmodule

// File: rtl/irqhub_ctrl.sv
module irqhub_ctrl
  import irqhub_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic [REG_W-1:0]  statusWord,
  input  logic [REG_W-1:0]  maskWord,
  input  logic [REG_W-1:0]  vectorWord,
  input  logic [REG_W-1:0]  targetWord,
  output regStrobe_t        strobe,
  output logic [REG_W-1:0]  regRdata,
  output logic              regRdValid
);
  rdSel_e           sel;
  logic [REG_W-1:0] rdMux;
  logic             rdReq;

  assign rdReq = regValid && !regWrite;

  always_comb begin
    sel = SEL_NONE;
    case (regAddr)
      ADDR_W'(OFS_STATUS): sel = SEL_STATUS;
      ADDR_W'(OFS_MASK):   sel = SEL_MASK;
      ADDR_W'(OFS_VECTOR): sel = SEL_VECTOR;
      ADDR_W'(OFS_TARGET): sel = SEL_TARGET;
      default:             sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe      = '0;
    strobe.data = regWdata;
    if (regValid && regWrite) begin
      case (sel)
        SEL_STATUS: strobe.clrStatus = 1'b1;
        SEL_MASK:   strobe.wrMask    = 1'b1;
        SEL_VECTOR: strobe.clrVector = 1'b1;
        SEL_TARGET: strobe.wrTarget  = 1'b1;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_STATUS: rdMux = statusWord;
      SEL_MASK:   rdMux = maskWord;
      SEL_VECTOR: rdMux = vectorWord;
      SEL_TARGET: rdMux = targetWord;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdValid <= 1'b0;
      regRdata   <= '0;
    end else begin
      regRdValid <= rdReq;
      if (rdReq) regRdata <= rdMux;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrStatus, strobe.wrMask, strobe.clrVector, strobe.wrTarget})); // R9
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> regRdValid); // R9
  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !regRdValid); // R9
endmodule

// File: rtl/irqhub_datapath.sv
module irqhub_datapath
  import irqhub_pkg::*;
#(
  parameter int NUM_VEC   = 32,
  parameter int IN_ADDR_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [NUM_INTX-1:0]  intxIn,
  input  logic                 inbValid,
  input  logic [IN_ADDR_W-1:0] inbAddr,
  input  logic [REG_W-1:0]     inbData,
  output logic [REG_W-1:0]     statusWord,
  output logic [REG_W-1:0]     maskWord,
  output logic [REG_W-1:0]     vectorWord,
  output logic [REG_W-1:0]     targetWord,
  output logic                 irqOut
);
  localparam int VEC_IDX_W = $clog2(NUM_VEC);

  logic [NUM_INTX-1:0]  intxBits, intxClr, maskIntx;
  logic [NUM_VEC-1:0]   vecBits, vecSet, vecClr;
  logic [VEC_IDX_W-1:0] hitIdx;
  logic [REG_W-1:0]     target;
  logic                 msiHit, anyVec, msiSum, maskMsi, sumClr;
  logic [REG_W-VEC_IDX_W-1:0] unusedPayload;

  assign unusedPayload = inbData[REG_W-1:VEC_IDX_W];
  assign hitIdx = inbData[VEC_IDX_W-1:0];
  // Only 32-bit targets: upper address half must be zero.
  assign msiHit = inbValid && (inbAddr[IN_ADDR_W-1:REG_W] == '0)
                  && (inbAddr[REG_W-1:0] == target);
  assign anyVec = |vecBits;
  assign sumClr = strobe.clrStatus && strobe.data[MSI_SUM_BIT];

  always_comb begin
    for (int i = 0; i < NUM_VEC; i++) begin
      vecSet[i] = msiHit && (hitIdx == VEC_IDX_W'(i));
      vecClr[i] = strobe.clrVector && strobe.data[i];
    end
    for (int j = 0; j < NUM_INTX; j++)
      intxClr[j] = strobe.clrStatus && strobe.data[INTX_LSB+j];
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    irqhub_stickybit u_bit (.clk(clk), .rstN(rstN), .setIn(vecSet[v]),
                            .clrIn(vecClr[v]), .q(vecBits[v]));
  end

  for (genvar k = 0; k < NUM_INTX; k++) begin : g_intx
    irqhub_stickybit u_bit (.clk(clk), .rstN(rstN), .setIn(intxIn[k]),
                            .clrIn(intxClr[k]), .q(intxBits[k]));
  end

  // Summary: a hit always sets it; pending vectors re-arm it after a clear.
  always_ff @(posedge clk) begin
    if (!rstN) msiSum <= 1'b0;
    else       msiSum <= msiHit | (~sumClr & (msiSum | anyVec));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskIntx <= '1;
      maskMsi  <= 1'b1;
      target   <= '0;
    end else begin
      if (strobe.wrMask) begin
        maskIntx <= strobe.data[INTX_LSB +: NUM_INTX];
        maskMsi  <= strobe.data[MSI_SUM_BIT];
      end
      if (strobe.wrTarget) target <= strobe.data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= (|(intxBits & ~maskIntx)) | (msiSum & ~maskMsi);
  end

  always_comb begin
    statusWord = '0;
    statusWord[INTX_LSB +: NUM_INTX] = intxBits;
    statusWord[MSI_SUM_BIT] = msiSum;
    maskWord = '0;
    maskWord[INTX_LSB +: NUM_INTX] = maskIntx;
    maskWord[MSI_SUM_BIT] = maskMsi;
    vectorWord = '0;
    vectorWord[NUM_VEC-1:0] = vecBits;
    targetWord = target;
  end

  AST_INTX_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|intxIn) |=> ((intxBits & $past(intxIn)) == $past(intxIn))); // R1
  AST_SUM_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (anyVec && !sumClr) |=> msiSum); // R2
  AST_HIT_SETS_VEC: assert property (@(posedge clk) disable iff (!rstN)
    msiHit |=> vecBits[$past(hitIdx)]); // R5
  AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (inbValid && (inbAddr[IN_ADDR_W-1:REG_W] != '0) && !strobe.clrVector)
    |=> $stable(vecBits)); // R6
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&{maskIntx, maskMsi}) |=> !irqOut); // R3
endmodule

// File: rtl/msi_intx_irq_hub.sv
module msi_intx_irq_hub
  import irqhub_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_VEC   = 32,
  parameter int IN_ADDR_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  output logic                 regRdValid,
  input  logic [NUM_INTX-1:0]  intxIn,
  input  logic                 inbValid,
  input  logic [IN_ADDR_W-1:0] inbAddr,
  input  logic [REG_W-1:0]     inbData,
  output logic                 irqOut
);
  regStrobe_t       strobe;
  logic [REG_W-1:0] statusWord, maskWord, vectorWord, targetWord;

  irqhub_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .statusWord(statusWord),
    .maskWord(maskWord), .vectorWord(vectorWord), .targetWord(targetWord),
    .strobe(strobe), .regRdata(regRdata), .regRdValid(regRdValid));

  irqhub_datapath #(.NUM_VEC(NUM_VEC), .IN_ADDR_W(IN_ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intxIn(intxIn),
    .inbValid(inbValid), .inbAddr(inbAddr), .inbData(inbData),
    .statusWord(statusWord), .maskWord(maskWord), .vectorWord(vectorWord),
    .targetWord(targetWord), .irqOut(irqOut));
endmodule

// File: tb/tb_msi_intx_irq_hub.sv
module tb_msi_intx_irq_hub;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regRdValid;
  logic [3:0]  intxIn = '0;
  logic        inbValid = 1'b0;
  logic [63:0] inbAddr = '0;
  logic [31:0] inbData = '0;
  logic        irqOut;

  int compared = 0, mismatched = 0;

  always #10 clk = ~clk; // 50 MHz

  msi_intx_irq_hub dut (.*);

  // Behavioural reference model, updated at every rising edge.
  logic [3:0]  mIntx;
  logic        mSum, mMaskM, mIrq, mRdv;
  logic [3:0]  mMaskI;
  logic [31:0] mVec, mAddr, mRd;

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00: return {8'h0, mSum, 3'b0, mIntx, 16'h0};
      8'h04: return {8'h0, mMaskM, 3'b0, mMaskI, 16'h0};
      8'h08: return mVec;
      8'h0C: return mAddr;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mIntx = '0; mSum = 0; mVec = '0; mAddr = '0;
      mMaskI = '1; mMaskM = 1; mIrq = 0; mRdv = 0; mRd = '0;
    end else begin
      logic hit, wr, clrS;
      logic [3:0]  nIntx;
      logic [31:0] nVec;
      logic        nSum;
      hit  = inbValid && inbAddr[63:32] == 0 && inbAddr[31:0] == mAddr;
      wr   = regValid && regWrite;
      mRdv = regValid && !regWrite;
      if (mRdv) mRd = modelRead(regAddr);
      clrS  = wr && regAddr == 8'h00 && regWdata[23];
      nIntx = (mIntx & ~((wr && regAddr == 8'h00) ? regWdata[19:16] : 4'h0)) | intxIn;
      nVec  = (mVec & ~((wr && regAddr == 8'h08) ? regWdata : 32'h0))
              | (hit ? (32'h1 << inbData[4:0]) : 32'h0);
      nSum  = hit || (!clrS && (mSum || mVec != 0));
      mIrq  = ((mIntx & ~mMaskI) != 0) || (mSum && !mMaskM);
      if (wr && regAddr == 8'h04) begin
        mMaskI = regWdata[19:16]; mMaskM = regWdata[23];
      end
      if (wr && regAddr == 8'h0C) mAddr = regWdata;
      mIntx = nIntx; mVec = nVec; mSum = nSum;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (rstN) begin
      check("R8 irqOut", {31'b0, irqOut}, {31'b0, mIrq});
      check("R9 rdValid", {31'b0, regRdValid}, {31'b0, mRdv});
      if (mRdv) check("R9 rdata", regRdata, mRd);
    end
  end

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regValid = 1; regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk); regValid = 0; regWrite = 0;
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); regValid = 1; regWrite = 0; regAddr = a;
    @(negedge clk); regValid = 0;
    check(tag, regRdata, exp);
  endtask

  task automatic sendMsi(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); inbValid = 1; inbAddr = a; inbData = d;
    @(negedge clk); inbValid = 0;
  endtask

  localparam logic [31:0] TGT = 32'hFEED_0040;

  initial begin
    fork
      begin : mainSeq
        repeat (3) @(negedge clk);
        rstN = 1;
        @(negedge clk);
        check("R10 irq after reset", {31'b0, irqOut}, 32'h0);
        expectRead(8'h00, 32'h0, "R10 status reset");
        expectRead(8'h04, 32'h008F_0000, "R3 mask reset");
        expectRead(8'h08, 32'h0, "R10 vector reset");
        expectRead(8'h0C, 32'h0, "R5 target reset");
        expectRead(8'h30, 32'h0, "R9 unmapped");
        doWrite(8'h0C, TGT);
        expectRead(8'h0C, TGT, "R5 target readback");
        sendMsi({32'h0, TGT}, 32'h5);
        expectRead(8'h08, 32'h0000_0020, "R5 vector 5 set");
        expectRead(8'h00, 32'h0080_0000, "R2 summary set");
        check("R3 masked msi", {31'b0, irqOut}, 32'h0);
        doWrite(8'h04, 32'hFFFF_FFFF);
        expectRead(8'h04, 32'h008F_0000, "R3 mask only defined bits");
        doWrite(8'h04, 32'h000F_0000);
        @(negedge clk);
        check("R8 irq raised", {31'b0, irqOut}, 32'h1);
        sendMsi({32'h1, TGT}, 32'h7);
        sendMsi({32'h0, TGT + 32'h4}, 32'h9);
        expectRead(8'h08, 32'h0000_0020, "R6 misses ignored");
        // Clear summary with vector pending, read in the very next cycle.
        @(negedge clk); regValid = 1; regWrite = 1; regAddr = 8'h00; regWdata = 32'h0080_0000;
        @(negedge clk); regWrite = 0;
        @(negedge clk); regValid = 0;
        check("R2 summary gap", regRdata, 32'h0);
        expectRead(8'h00, 32'h0080_0000, "R2 summary re-armed");
        doWrite(8'h08, 32'h0000_0020);
        expectRead(8'h08, 32'h0, "R4 vector cleared");
        doWrite(8'h00, 32'h0080_0000);
        expectRead(8'h00, 32'h0, "R2 summary cleared");
        check("R8 irq dropped", {31'b0, irqOut}, 32'h0);
        // Set and clear on vector 31 at the same edge.
        @(negedge clk); regValid = 1; regWrite = 1; regAddr = 8'h08; regWdata = 32'h8000_0000;
        inbValid = 1; inbAddr = {32'h0, TGT}; inbData = 32'd31;
        @(negedge clk); regValid = 0; regWrite = 0; inbValid = 0;
        expectRead(8'h08, 32'h8000_0000, "R7 vector set wins");
        sendMsi({32'h0, TGT}, 32'hFFFF_FFE0);
        expectRead(8'h08, 32'h8000_0001, "R5 index from low payload bits");
        doWrite(8'h08, 32'hFFFF_FFFF);
        doWrite(8'h00, 32'h0080_0000);
        expectRead(8'h00, 32'h0, "R4 all cleared");
        // Wire interrupts.
        doWrite(8'h04, 32'h0080_0000);
        @(negedge clk); intxIn = 4'b0010;
        @(negedge clk);
        @(negedge clk);
        check("R8 intx irq", {31'b0, irqOut}, 32'h1);
        doWrite(8'h00, 32'h000F_0000);
        expectRead(8'h00, 32'h0002_0000, "R7 intx set wins");
        intxIn = 4'b1000;
        @(negedge clk); intxIn = 4'b0000;
        doWrite(8'h00, 32'h0002_0000);
        expectRead(8'h00, 32'h0008_0000, "R1 INTD held, INTB cleared");
        doWrite(8'h04, 32'h008F_0000);
        @(negedge clk);
        check("R3 all masked", {31'b0, irqOut}, 32'h0);
        doWrite(8'h00, 32'h0008_0000);
        expectRead(8'h00, 32'h0, "R1 INTD cleared");
        repeat (3) @(negedge clk);
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule